// File: doc/BRIEF.md
# Bit-Error-Tolerant Page Verify Comparator

This block checks a page read back from freshly programmed NAND against the image it was written from, without decoding any error-correcting code. Two byte streams arrive side by side: the bytes read from the device and the bytes expected from the image. Each pair of bytes is XORed and the differing bits are counted. The count is added to a running total for the current sector. Spare-area bytes, including the ECC bytes that were computed in advance and stored there, go through the same comparison as data bytes.

A sector covers a run-time number of bytes, or ends early when the page ends. When a sector closes, its flipped-bit total is reported and compared with a tolerance. The tolerance is set to the number of bit errors the target system's ECC can correct in a sector of that size. A sector at or below the tolerance is acceptable. The page fails when any of its sectors goes over the tolerance, or when the two streams disagree about where the page ends. At the end of each page the block reports a pass/fail result and the worst sector total seen in that page.

Top module: `tol_verify_cmp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sec_valid` and `page_valid` are low.
- R2: A byte pair is consumed only in a cycle where `rd_valid` and `ex_valid` are both high. `rd_ready` follows `ex_valid` and `ex_ready` follows `rd_valid`, so a stream that is valid alone is held and never counted.
- R3: The bit errors of a byte pair are the number of 1 bits in `rd_data ^ ex_data`. Each sector's total is the sum over its byte pairs. It appears on `sec_errs`, with a one-cycle `sec_valid` pulse, in the cycle after the sector's last pair is consumed.
- R4: A sector closes after `cfg_sector_bytes` pairs (the value must be 1 or more). The next sector starts again from zero, so each sector is judged independently.
- R5: The pair that carries the end-of-page flag also closes the current sector, even if the sector is shorter than `cfg_sector_bytes`.
- R6: A sector total saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R7: `sec_over` is 1 when the sector total is strictly greater than `cfg_tol`. A total equal to `cfg_tol` is not over.
- R8: `page_valid` pulses for one cycle, in the cycle after the end-of-page pair is consumed. `page_pass` is 1 only if no sector of that page was over tolerance and there was no length error.
- R9: `page_worst` is the largest sector total of the page that just ended.
- R10: A consumed pair where exactly one of `rd_last` and `ex_last` is set ends the page. That page reports `page_len_err`=1 and `page_pass`=0.
- R11: The failure flag and the worst total clear at each page end, so a failure never carries into the next page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized upstream |
| cfg_sector_bytes | input | SEC_W (11) | Bytes per sector, 1 or more |
| cfg_tol | input | CNT_W (8) | Largest acceptable flipped-bit total per sector |
| rd_valid | input | 1 | A byte read from the device is offered |
| rd_ready | output | 1 | Read-back byte accepted this cycle when valid |
| rd_data | input | DATA_W (8) | Byte read from the device |
| rd_last | input | 1 | Last read-back byte of the page |
| ex_valid | input | 1 | An expected image byte is offered |
| ex_ready | output | 1 | Expected byte accepted this cycle when valid |
| ex_data | input | DATA_W (8) | Expected byte from the image |
| ex_last | input | 1 | Last expected byte of the page |
| sec_valid | output | 1 | One-cycle pulse: a sector has closed |
| sec_errs | output | CNT_W (8) | Saturated flipped-bit total of that sector |
| sec_over | output | 1 | That sector's total is over `cfg_tol` |
| page_valid | output | 1 | One-cycle pulse: a page has closed |
| page_pass | output | 1 | The page is acceptable |
| page_worst | output | CNT_W (8) | Largest sector total in the page |
| page_len_err | output | 1 | The streams ended the page on different bytes |

## Verification
The case that needs care is a page whose last byte also fills a sector, or whose last sector is a short one. In that cycle the sector close and the page close happen together. The total of that final sector has to reach both the failure flag and the worst value in the same cycle as it is reported. The bench provokes this with pages whose final sector is the only one over tolerance, or holds the largest total, including a saturating 64-byte sector. It judges the result by requiring that the page result agrees with that sector's own report, which arrives in the same cycle. A tolerance exactly equal to a sector's total is also driven, to confirm that equality passes.

// File: rtl/tol_verify_pkg.sv
`timescale 1ns/1ps
package tol_verify_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned SEC_W_DEF  = 11;
endpackage

// File: rtl/tv_bit_diff.sv
`timescale 1ns/1ps
module tv_bit_diff #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PC_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [PC_W-1:0]   flips
);
  logic [DATA_W-1:0] diff;

  for (genvar i = 0; i < DATA_W; i++) begin : g_xor
    assign diff[i] = a[i] ^ b[i];
  end

  always_comb begin
    flips = '0;
    for (int i = 0; i < DATA_W; i++) flips = flips + PC_W'(diff[i]);
  end
endmodule

// File: rtl/tv_sector_acc.sv
`timescale 1ns/1ps
module tv_sector_acc #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PC_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             close,
  input  logic [PC_W-1:0]  flips,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] acc_q, acc_d;
  logic [CNT_W:0]   wide;

  // saturating sum including the current pair
  always_comb begin
    wide  = {1'b0, acc_q} + {{(CNT_W + 1 - PC_W){1'b0}}, flips};
    total = wide[CNT_W] ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
    acc_d = acc_q;
    if (take) acc_d = close ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= acc_d;
  end
endmodule

// File: rtl/tv_page_track.sv
`timescale 1ns/1ps
module tv_page_track #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             rd_last,
  input  logic             ex_last,
  input  logic [SEC_W-1:0] cfg_sector_bytes,
  input  logic [CNT_W-1:0] cfg_tol,
  input  logic [CNT_W-1:0] total,
  output logic             close,
  output logic             sec_valid,
  output logic [CNT_W-1:0] sec_errs,
  output logic             sec_over,
  output logic             page_valid,
  output logic             page_pass,
  output logic [CNT_W-1:0] page_worst,
  output logic             page_len_err
);
  logic [SEC_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] worst_q, worst_d;
  logic             fail_q, fail_d;
  logic             page_end, len_bad, over;
  logic             sv_d, so_d, pv_d, pp_d, pl_d;
  logic [CNT_W-1:0] se_d, pw_d;

  always_comb begin
    page_end = take & (rd_last | ex_last);
    len_bad  = take & (rd_last ^ ex_last);
    close    = take & ((cnt_q == cfg_sector_bytes - 1'b1) | rd_last | ex_last);
    over     = total > cfg_tol;

    cnt_d = cnt_q;
    if (take) cnt_d = close ? '0 : cnt_q + 1'b1;

    fail_d  = fail_q | (close & over) | len_bad;
    worst_d = (close && total > worst_q) ? total : worst_q;

    sv_d = close;
    se_d = close ? total : sec_errs;
    so_d = close ? over  : sec_over;
    pv_d = page_end;
    pp_d = page_end ? ~fail_d : page_pass;
    pw_d = page_end ? worst_d : page_worst;
    pl_d = page_end ? len_bad : page_len_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      worst_q      <= '0;
      fail_q       <= 1'b0;
      sec_valid    <= 1'b0;
      sec_errs     <= '0;
      sec_over     <= 1'b0;
      page_valid   <= 1'b0;
      page_pass    <= 1'b0;
      page_worst   <= '0;
      page_len_err <= 1'b0;
    end else begin
      sec_valid  <= sv_d;
      page_valid <= pv_d;
      sec_errs   <= se_d;
      sec_over   <= so_d;
      page_pass  <= pp_d;
      page_worst <= pw_d;
      page_len_err <= pl_d;
      if (take) begin
        cnt_q   <= cnt_d;
        fail_q  <= page_end ? 1'b0 : fail_d;
        worst_q <= page_end ? '0 : worst_d;
      end
    end
  end
endmodule

// File: rtl/tol_verify_cmp.sv
`timescale 1ns/1ps
module tol_verify_cmp
  import tol_verify_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned SEC_W  = SEC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEC_W-1:0]  cfg_sector_bytes,
  input  logic [CNT_W-1:0]  cfg_tol,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_last,
  input  logic              ex_valid,
  output logic              ex_ready,
  input  logic [DATA_W-1:0] ex_data,
  input  logic              ex_last,
  output logic              sec_valid,
  output logic [CNT_W-1:0]  sec_errs,
  output logic              sec_over,
  output logic              page_valid,
  output logic              page_pass,
  output logic [CNT_W-1:0]  page_worst,
  output logic              page_len_err
);
  localparam int unsigned PC_W = $clog2(DATA_W + 1);

  logic            take, close;
  logic [PC_W-1:0] flips;
  logic [CNT_W-1:0] total;

  // each side waits for the other; a pair moves only when both are offered
  assign rd_ready = ex_valid;
  assign ex_ready = rd_valid;
  assign take     = rd_valid & ex_valid;

  tv_bit_diff #(.DATA_W(DATA_W)) u_diff (
    .a(rd_data), .b(ex_data), .flips(flips)
  );

  tv_sector_acc #(.CNT_W(CNT_W), .PC_W(PC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .close(close),
    .flips(flips), .total(total)
  );

  tv_page_track #(.CNT_W(CNT_W), .SEC_W(SEC_W)) u_page (
    .clk(clk), .rst_n(rst_n), .take(take),
    .rd_last(rd_last), .ex_last(ex_last),
    .cfg_sector_bytes(cfg_sector_bytes), .cfg_tol(cfg_tol),
    .total(total), .close(close),
    .sec_valid(sec_valid), .sec_errs(sec_errs), .sec_over(sec_over),
    .page_valid(page_valid), .page_pass(page_pass),
    .page_worst(page_worst), .page_len_err(page_len_err)
  );
endmodule

// File: rtl/tol_verify_chk.sv
`timescale 1ns/1ps
module tol_verify_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             ex_valid,
  input logic             sec_valid,
  input logic [CNT_W-1:0] sec_errs,
  input logic             sec_over,
  input logic             page_valid,
  input logic             page_pass,
  input logic [CNT_W-1:0] page_worst,
  input logic             page_len_err
);
  // R3
  sec_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> $past(rd_valid && ex_valid));

  // R5
  page_closes_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_valid |-> sec_valid);

  // R8
  pass_needs_last_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_valid && page_pass) |-> !sec_over);

  // R9
  worst_covers_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_valid |-> (page_worst >= sec_errs));

  // R10
  len_err_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_valid && page_len_err) |-> !page_pass);
endmodule

bind tol_verify_cmp tol_verify_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .ex_valid(ex_valid),
  .sec_valid(sec_valid), .sec_errs(sec_errs), .sec_over(sec_over),
  .page_valid(page_valid), .page_pass(page_pass),
  .page_worst(page_worst), .page_len_err(page_len_err)
);

// File: tb/tb_tol_verify_cmp.sv
`timescale 1ns/1ps
module tb_tol_verify_cmp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] cfg_sector_bytes;
  logic [7:0]  cfg_tol;
  logic        rd_valid, rd_last, ex_valid, ex_last;
  logic        rd_ready, ex_ready;
  logic [7:0]  rd_data, ex_data;
  logic        sec_valid, sec_over, page_valid, page_pass, page_len_err;
  logic [7:0]  sec_errs, page_worst;

  int checks = 0;
  int fails  = 0;
  int sq[$];
  int oq[$];
  int pg_seen;
  int pg_pass, pg_worst, pg_len;
  logic [7:0] rbuf [0:63];
  logic [7:0] ebuf [0:63];

  always #4 clk = ~clk;

  tol_verify_cmp dut (
    .clk(clk), .rst_n(rst_n), .cfg_sector_bytes(cfg_sector_bytes), .cfg_tol(cfg_tol),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_data(ex_data), .ex_last(ex_last),
    .sec_valid(sec_valid), .sec_errs(sec_errs), .sec_over(sec_over),
    .page_valid(page_valid), .page_pass(page_pass), .page_worst(page_worst),
    .page_len_err(page_len_err)
  );

  always @(negedge clk) begin
    if (sec_valid) begin
      sq.push_back(int'(sec_errs));
      oq.push_back(int'(sec_over));
    end
    if (page_valid) begin
      pg_seen++;
      pg_pass  = int'(page_pass);
      pg_worst = int'(page_worst);
      pg_len   = int'(page_len_err);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    sq.delete();
    oq.delete();
    pg_seen = 0;
  endtask

  task automatic clear_bufs();
    for (int i = 0; i < 64; i++) begin
      rbuf[i] = 8'(i * 7 + 3);
      ebuf[i] = 8'(i * 7 + 3);
    end
  endtask

  // drives n pairs; rd_last at index rl, ex_last at index el
  task automatic run_page(input int n, input int rl, input int el);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_valid = 1'b1; ex_valid = 1'b1;
      rd_data = rbuf[i]; ex_data = ebuf[i];
      rd_last = (i == rl); ex_last = (i == el);
      @(posedge clk);
    end
    @(negedge clk);
    rd_valid = 1'b0; ex_valid = 1'b0; rd_last = 1'b0; ex_last = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rd_valid = 0; ex_valid = 0; rd_last = 0; ex_last = 0; rd_data = 0; ex_data = 0;
    cfg_sector_bytes = 11'd4; cfg_tol = 8'd2;
    repeat (3) @(posedge clk);
    #1;
    check(sec_valid == 0 && page_valid == 0, "R1 reset outputs", int'(sec_valid | page_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(sec_valid == 0 && page_valid == 0, "R1 after release", int'(sec_valid | page_valid), 0);
  endtask

  task automatic t_clean();
    clear_bufs(); clear_log();
    cfg_sector_bytes = 11'd4; cfg_tol = 8'd2;
    run_page(8, 7, 7);
    check(sq.size() == 2, "R4 two sectors", sq.size(), 2);
    if (sq.size() == 2) check(sq[0] == 0 && sq[1] == 0, "R3 clean totals", sq[0] + sq[1], 0);
    check(pg_seen == 1 && pg_pass == 1, "R8 clean page pass", pg_pass, 1);
    check(pg_worst == 0, "R9 clean worst", pg_worst, 0);
  endtask

  task automatic t_over();
    clear_bufs(); clear_log();
    cfg_sector_bytes = 11'd4; cfg_tol = 8'd2;
    rbuf[0] = ebuf[0] ^ 8'h03;
    rbuf[4] = ebuf[4] ^ 8'h01; rbuf[5] = ebuf[5] ^ 8'h10; rbuf[6] = ebuf[6] ^ 8'h80;
    run_page(8, 7, 7);
    check(sq.size() == 2, "R4 sector count", sq.size(), 2);
    if (sq.size() == 2) begin
      check(sq[0] == 2, "R3 sector0 total", sq[0], 2);
      check(sq[1] == 3, "R3 sector1 total", sq[1], 3);
      check(oq[0] == 0, "R7 equal not over", oq[0], 0);
      check(oq[1] == 1, "R7 above is over", oq[1], 1);
    end
    check(pg_pass == 0, "R8 page fails", pg_pass, 0);
    check(pg_worst == 3, "R9 worst", pg_worst, 3);
  endtask

  task automatic t_next_page();
    clear_bufs(); clear_log();
    rbuf[1] = ebuf[1] ^ 8'h01;
    run_page(8, 7, 7);
    check(pg_pass == 1, "R11 fail cleared", pg_pass, 1);
    check(pg_worst == 1, "R11 worst cleared", pg_worst, 1);
  endtask

  task automatic t_short_sector();
    clear_bufs(); clear_log();
    cfg_sector_bytes = 11'd4; cfg_tol = 8'd8;
    rbuf[2] = ebuf[2] ^ 8'h01;
    rbuf[5] = ebuf[5] ^ 8'hFF;
    run_page(6, 5, 5);
    check(sq.size() == 2, "R5 short tail sector", sq.size(), 2);
    if (sq.size() == 2) begin
      check(sq[0] == 1, "R4 first sector", sq[0], 1);
      check(sq[1] == 8, "R5 tail total", sq[1], 8);
      check(oq[1] == 0, "R7 tail equal tol", oq[1], 0);
    end
    check(pg_pass == 1 && pg_worst == 8, "R9 tail worst pass", pg_worst, 8);
  endtask

  task automatic t_saturate();
    clear_bufs(); clear_log();
    cfg_sector_bytes = 11'd64; cfg_tol = 8'd254;
    for (int i = 0; i < 64; i++) rbuf[i] = ~ebuf[i];
    run_page(64, 63, 63);
    check(sq.size() == 1, "R6 one sector", sq.size(), 1);
    if (sq.size() == 1) check(sq[0] == 255, "R6 saturated", sq[0], 255);
    check(pg_pass == 0 && pg_worst == 255, "R6 page worst", pg_worst, 255);
  endtask

  task automatic t_handshake();
    clear_log();
    cfg_sector_bytes = 11'd1; cfg_tol = 8'd0;
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 8'hFF; ex_data = 8'h00; rd_last = 1'b1; ex_last = 1'b1;
    #1;
    check(rd_ready == 0 && ex_ready == 1, "R2 ready cross", int'({rd_ready, ex_ready}), 1);
    repeat (4) @(posedge clk);
    #1;
    check(sq.size() == 0 && pg_seen == 0, "R2 lone stream held", sq.size(), 0);
    @(negedge clk);
    rd_data = 8'h00; ex_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 0; ex_valid = 0; rd_last = 0; ex_last = 0;
    repeat (3) @(posedge clk);
    #1;
    check(sq.size() == 1, "R2 one pair taken", sq.size(), 1);
    if (sq.size() == 1) check(sq[0] == 0, "R2 held data unused", sq[0], 0);
    check(pg_pass == 1, "R2 page pass", pg_pass, 1);
  endtask

  task automatic t_length();
    clear_bufs(); clear_log();
    cfg_sector_bytes = 11'd4; cfg_tol = 8'd2;
    run_page(3, 2, 99);
    check(pg_seen == 1, "R10 page closed", pg_seen, 1);
    check(pg_len == 1, "R10 length flag", pg_len, 1);
    check(pg_pass == 0, "R10 page fails", pg_pass, 0);
    check(sq.size() == 1, "R5 sector closed by end", sq.size(), 1);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_over();
    t_next_page();
    t_short_sector();
    t_saturate();
    t_handshake();
    t_length();
    t_next_page();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule